// File: doc/BRIEF.md
# Gated Asynchronous Serial Receiver

This block turns a single asynchronous serial line into characters in a small receive queue. A baud-rate enable (`tick16`, sixteen pulses per bit time) paces it. The line first passes through a synchronizer. A falling line starts a frame, and the receiver confirms that start bit at its centre. It then collects the data bits least significant first, an optional parity bit, and one or two stop bits. Each finished character enters a 16-entry queue together with two status bits: a parity error bit and a stop (framing) error bit.

Before a character is written, the receiver makes four checks: the stop bit, whether the frame is a break, whether the queue has room, and whether a break or overrun condition is still pending. A character is written only when no break or overrun condition is pending. A parity or framing error marks the character but never stops reception. Three sticky flags record receive errors, breaks and overruns, and each has its own clear strobe. A fill flag compares the queue level with a programmable trigger. Three interrupt requests are built from the flags and two enables that they share.

Top module: `serial_rx_gated`

## Requirements
- R1: After reset, `fifo_count` is 0 and every flag and every interrupt output is 0.
- R2: A low level on `rxd` that is already high again at the centre of the start bit (8th sample tick after detection) is treated as noise: no character is produced and no flag changes.
- R3: Data bits are taken least significant bit first. When `cfg_par_en`=1, one parity bit follows the data bits, with even parity when `cfg_par_odd`=0 and odd parity when it is 1. An accepted character appears at the queue head on `rd_data`.
- R4: Only the first stop bit is checked. If it samples as 0, the stored entry has `rd_ferr`=1 and `flag_err` is set. With `cfg_two_stop`=1, the value of the second stop bit has no effect.
- R5: A parity mismatch stores the character with `rd_perr`=1 and sets `flag_err`. Later characters are still received and stored.
- R6: A frame whose data bits, parity bit (if enabled) and first stop bit are all 0 is a break. It sets `flag_brk` and `flag_err` and is not stored. The receiver then waits for the line to return high, so a long low period produces exactly one break event.
- R7: A character that is not a break and completes while the queue holds 16 entries sets `flag_ovr` and is discarded. The entries already in the queue are kept.
- R8: While `flag_brk` or `flag_ovr` is 1, every completed character is discarded, whatever its errors.
- R9: `flag_err`, `flag_brk` and `flag_ovr` stay set until `clr_err`, `clr_brk` or `clr_ovr` is pulsed. A new setting event in the same cycle wins over the clear.
- R10: The queue holds 16 entries and never reports more. A pulse on `rd_en` removes the head entry. `flag_fill` is 1 while `fifo_count` is at least the trigger level, where a `cfg_trigger` of 0 acts as 1 and a value above 16 acts as 16.
- R11: `irq_fill` = `en_rx_irq` AND `flag_fill`. `irq_rx_err` = (`en_rx_irq` OR `en_err_irq`) AND `flag_err`. `irq_brk_ovr` = (`en_rx_irq` OR `en_err_irq`) AND (`flag_brk` OR `flag_ovr`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Sample enable, 16 per bit time |
| rxd | input | 1 | Serial line, idle high |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 even |
| cfg_two_stop | input | 1 | Two stop bits per frame |
| cfg_trigger | input | 5 | Queue level at which the fill flag rises |
| en_rx_irq | input | 1 | Receive interrupt enable |
| en_err_irq | input | 1 | Receive-error interrupt enable |
| clr_err | input | 1 | Clears the error flag |
| clr_brk | input | 1 | Clears the break flag |
| clr_ovr | input | 1 | Clears the overrun flag |
| rd_en | input | 1 | Removes the queue head entry |
| rd_data | output | 8 | Data byte at the queue head |
| rd_perr | output | 1 | Parity error bit of the head entry |
| rd_ferr | output | 1 | Framing error bit of the head entry |
| fifo_count | output | 5 | Number of queued entries |
| flag_fill | output | 1 | Level has reached the trigger |
| flag_err | output | 1 | Sticky parity/framing error |
| flag_brk | output | 1 | Sticky break |
| flag_ovr | output | 1 | Sticky overrun |
| irq_fill | output | 1 | Fill interrupt request |
| irq_rx_err | output | 1 | Receive-error interrupt request |
| irq_brk_ovr | output | 1 | Break/overrun interrupt request |

## Verification
The fill flag and all three interrupt requests are combinational functions of the queue level and the sticky flags. The bench therefore compares them with its own computation on every clock, 2 ns after the falling edge. A character's effect on the queue and flags lands about 11 sample ticks into the first stop bit plus one clock. That is well inside the two idle bit times (32 clocks) that the bench sends after each frame, so queue level, flags and head entry are compared only after that idle gap, against a queue-based model. A read or clear takes effect at the next rising edge, and the bench samples at the falling edge that follows it.

// File: rtl/srx_pkg.sv
package srx_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_START,
      PH_DATA,
      PH_PARITY,
      PH_STOP1,
      PH_STOP2,
      PH_HOLD
   } rx_phase_e;

   function automatic int unsigned eff_trigger(input int unsigned raw, input int unsigned depth);
      if (raw == 0)
         return 1;
      else if (raw > depth)
         return depth;
      else
         return raw;
   endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   generate
      if (STAGES == 1) begin : g_single
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b1;
            else        q <= din;
         end
         assign dout = q;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], din};
         end
         assign dout = chain[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/srx_frame.sv
module srx_frame
   import srx_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int OVERSAMPLE = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rx,
   input  logic              cfg_par_en,
   input  logic              cfg_par_odd,
   input  logic              cfg_two_stop,
   output logic              done,
   output logic [DATA_W-1:0] done_data,
   output logic              done_perr,
   output logic              done_ferr,
   output logic              done_break
);

   localparam int CNT_W       = $clog2(2 * OVERSAMPLE);
   localparam int IDX_W       = $clog2(DATA_W + 1);
   localparam int MID_TICK    = OVERSAMPLE / 2 - 1;
   localparam int LAST_TICK   = OVERSAMPLE - 1;
   localparam int STOP2_TICKS = OVERSAMPLE + OVERSAMPLE / 4;

   rx_phase_e         phase;
   logic [CNT_W-1:0]  cnt;
   logic [IDX_W-1:0]  idx;
   logic [DATA_W-1:0] shreg;
   logic              par_bit;
   logic              any_one;
   logic              bit_end;

   assign bit_end = (cnt == CNT_W'(LAST_TICK));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase      <= PH_IDLE;
         cnt        <= '0;
         idx        <= '0;
         shreg      <= '0;
         par_bit    <= 1'b0;
         any_one    <= 1'b0;
         done       <= 1'b0;
         done_data  <= '0;
         done_perr  <= 1'b0;
         done_ferr  <= 1'b0;
         done_break <= 1'b0;
      end else begin
         done <= 1'b0;
         if (tick) begin
            unique case (phase)
               PH_IDLE: begin
                  if (!rx) begin
                     phase <= PH_START;
                     cnt   <= '0;
                  end
               end
               PH_START: begin
                  if (cnt == CNT_W'(MID_TICK)) begin
                     cnt <= '0;
                     if (rx) begin
                        phase <= PH_IDLE;
                     end else begin
                        phase   <= PH_DATA;
                        idx     <= '0;
                        any_one <= 1'b0;
                        par_bit <= 1'b0;
                     end
                  end else begin
                     cnt <= cnt + CNT_W'(1);
                  end
               end
               PH_DATA: begin
                  if (bit_end) begin
                     cnt     <= '0;
                     shreg   <= {rx, shreg[DATA_W-1:1]};
                     any_one <= any_one | rx;
                     if (idx == IDX_W'(DATA_W - 1))
                        phase <= cfg_par_en ? PH_PARITY : PH_STOP1;
                     else
                        idx <= idx + IDX_W'(1);
                  end else begin
                     cnt <= cnt + CNT_W'(1);
                  end
               end
               PH_PARITY: begin
                  if (bit_end) begin
                     cnt     <= '0;
                     par_bit <= rx;
                     any_one <= any_one | rx;
                     phase   <= PH_STOP1;
                  end else begin
                     cnt <= cnt + CNT_W'(1);
                  end
               end
               PH_STOP1: begin
                  if (bit_end) begin
                     cnt        <= '0;
                     done       <= 1'b1;
                     done_data  <= shreg;
                     done_ferr  <= ~rx;
                     done_perr  <= cfg_par_en & ((^shreg ^ par_bit) != cfg_par_odd);
                     done_break <= ~any_one & ~rx;
                     if (~any_one & ~rx)
                        phase <= PH_HOLD;
                     else if (cfg_two_stop)
                        phase <= PH_STOP2;
                     else
                        phase <= PH_IDLE;
                  end else begin
                     cnt <= cnt + CNT_W'(1);
                  end
               end
               PH_STOP2: begin
                  if (cnt == CNT_W'(STOP2_TICKS - 1)) begin
                     cnt   <= '0;
                     phase <= PH_IDLE;
                  end else begin
                     cnt <= cnt + CNT_W'(1);
                  end
               end
               PH_HOLD: begin
                  if (rx) phase <= PH_IDLE;
               end
               default: phase <= PH_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/srx_fifo.sv
module srx_fifo #(
   parameter int WIDTH = 10,
   parameter int DEPTH = 16,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] wdata,
   input  logic             pop,
   output logic [WIDTH-1:0] rdata,
   output logic [CNT_W-1:0] count
);

   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr;
   logic [PTR_W-1:0] rd_ptr;
   logic             do_push;
   logic             do_pop;

   assign do_push = push && (count != CNT_W'(DEPTH));
   assign do_pop  = pop  && (count != '0);
   assign rdata   = mem[rd_ptr];

   function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
   endfunction

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= step(wr_ptr);
         if (do_pop)  rd_ptr <= step(rd_ptr);
         unique case ({do_push, do_pop})
            2'b10:   count <= count + CNT_W'(1);
            2'b01:   count <= count - CNT_W'(1);
            default: count <= count;
         endcase
      end
   end

endmodule

// File: rtl/srx_status.sv
module srx_status
   import srx_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             done,
   input  logic             done_perr,
   input  logic             done_ferr,
   input  logic             done_break,
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] cfg_trigger,
   input  logic             en_rx_irq,
   input  logic             en_err_irq,
   input  logic             clr_err,
   input  logic             clr_brk,
   input  logic             clr_ovr,
   output logic             push,
   output logic             flag_fill,
   output logic             flag_err,
   output logic             flag_brk,
   output logic             flag_ovr,
   output logic             irq_fill,
   output logic             irq_rx_err,
   output logic             irq_brk_ovr
);

   logic             full;
   logic             gate_open;
   logic [CNT_W-1:0] trig_eff;

   assign full      = (count == CNT_W'(DEPTH));
   assign gate_open = ~flag_brk & ~flag_ovr;
   assign push      = done & ~done_break & ~full & gate_open;

   always_comb begin
      trig_eff  = CNT_W'(eff_trigger(int'(cfg_trigger), DEPTH));
      flag_fill = (count >= trig_eff);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_err <= 1'b0;
         flag_brk <= 1'b0;
         flag_ovr <= 1'b0;
      end else begin
         if (done && (done_perr || done_ferr)) flag_err <= 1'b1;
         else if (clr_err)                     flag_err <= 1'b0;

         if (done && done_break)               flag_brk <= 1'b1;
         else if (clr_brk)                     flag_brk <= 1'b0;

         if (done && !done_break && full)      flag_ovr <= 1'b1;
         else if (clr_ovr)                     flag_ovr <= 1'b0;
      end
   end

   logic any_en;
   assign any_en      = en_rx_irq | en_err_irq;
   assign irq_fill    = en_rx_irq & flag_fill;
   assign irq_rx_err  = any_en & flag_err;
   assign irq_brk_ovr = any_en & (flag_brk | flag_ovr);

endmodule

// File: rtl/serial_rx_gated.sv
module serial_rx_gated #(
   parameter int DATA_W      = 8,
   parameter int DEPTH       = 16,
   parameter int OVERSAMPLE  = 16,
   parameter int SYNC_STAGES = 2,
   localparam int CNT_W      = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick16,
   input  logic              rxd,
   input  logic              cfg_par_en,
   input  logic              cfg_par_odd,
   input  logic              cfg_two_stop,
   input  logic [CNT_W-1:0]  cfg_trigger,
   input  logic              en_rx_irq,
   input  logic              en_err_irq,
   input  logic              clr_err,
   input  logic              clr_brk,
   input  logic              clr_ovr,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_perr,
   output logic              rd_ferr,
   output logic [CNT_W-1:0]  fifo_count,
   output logic              flag_fill,
   output logic              flag_err,
   output logic              flag_brk,
   output logic              flag_ovr,
   output logic              irq_fill,
   output logic              irq_rx_err,
   output logic              irq_brk_ovr
);

   localparam int ENTRY_W = DATA_W + 2;

   initial begin
      assert (DATA_W >= 2)      else $error("DATA_W must be at least 2");
      assert (DEPTH >= 2)       else $error("DEPTH must be at least 2");
      assert (OVERSAMPLE >= 4)  else $error("OVERSAMPLE must be at least 4");
      assert (SYNC_STAGES >= 1) else $error("SYNC_STAGES must be at least 1");
   end

   logic              rx_s;
   logic              done;
   logic [DATA_W-1:0] done_data;
   logic              done_perr;
   logic              done_ferr;
   logic              done_break;
   logic              push;
   logic [ENTRY_W-1:0] head;

   srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (rxd),
      .dout  (rx_s)
   );

   srx_frame #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_frame (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick         (tick16),
      .rx           (rx_s),
      .cfg_par_en   (cfg_par_en),
      .cfg_par_odd  (cfg_par_odd),
      .cfg_two_stop (cfg_two_stop),
      .done         (done),
      .done_data    (done_data),
      .done_perr    (done_perr),
      .done_ferr    (done_ferr),
      .done_break   (done_break)
   );

   srx_status #(.DEPTH(DEPTH)) u_status (
      .clk         (clk),
      .rst_n       (rst_n),
      .done        (done),
      .done_perr   (done_perr),
      .done_ferr   (done_ferr),
      .done_break  (done_break),
      .count       (fifo_count),
      .cfg_trigger (cfg_trigger),
      .en_rx_irq   (en_rx_irq),
      .en_err_irq  (en_err_irq),
      .clr_err     (clr_err),
      .clr_brk     (clr_brk),
      .clr_ovr     (clr_ovr),
      .push        (push),
      .flag_fill   (flag_fill),
      .flag_err    (flag_err),
      .flag_brk    (flag_brk),
      .flag_ovr    (flag_ovr),
      .irq_fill    (irq_fill),
      .irq_rx_err  (irq_rx_err),
      .irq_brk_ovr (irq_brk_ovr)
   );

   srx_fifo #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .wdata ({done_perr, done_ferr, done_data}),
      .pop   (rd_en),
      .rdata (head),
      .count (fifo_count)
   );

   assign rd_data = head[DATA_W-1:0];
   assign rd_ferr = head[DATA_W];
   assign rd_perr = head[DATA_W+1];

endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
   parameter int DEPTH = 16,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] fifo_count,
   input logic             flag_fill,
   input logic             flag_err,
   input logic             flag_brk,
   input logic             flag_ovr,
   input logic             clr_err,
   input logic             clr_brk,
   input logic             clr_ovr,
   input logic             en_rx_irq,
   input logic             en_err_irq,
   input logic             irq_fill,
   input logic             irq_rx_err,
   input logic             irq_brk_ovr
);

   assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_count <= CNT_W'(DEPTH));

   assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flag_err && !clr_err |=> flag_err);

   assert_brk_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flag_brk && !clr_brk |=> flag_brk);

   assert_ovr_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flag_ovr && !clr_ovr |=> flag_ovr);

   assert_gate_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_brk || flag_ovr) |=> fifo_count <= $past(fifo_count));

   assert_ovr_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_ovr) |-> $past(fifo_count) == CNT_W'(DEPTH));

   assert_brk_request_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_brk || flag_ovr) && (en_rx_irq || en_err_irq) |-> irq_brk_ovr);

   assert_fill_request_R11: assert property (@(posedge clk) disable iff (!rst_n)
      irq_fill |-> en_rx_irq && flag_fill);

   assert_err_request_R11: assert property (@(posedge clk) disable iff (!rst_n)
      irq_rx_err |-> flag_err && (en_rx_irq || en_err_irq));

endmodule

bind serial_rx_gated srx_checker #(.DEPTH(DEPTH)) u_srx_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .fifo_count  (fifo_count),
   .flag_fill   (flag_fill),
   .flag_err    (flag_err),
   .flag_brk    (flag_brk),
   .flag_ovr    (flag_ovr),
   .clr_err     (clr_err),
   .clr_brk     (clr_brk),
   .clr_ovr     (clr_ovr),
   .en_rx_irq   (en_rx_irq),
   .en_err_irq  (en_err_irq),
   .irq_fill    (irq_fill),
   .irq_rx_err  (irq_rx_err),
   .irq_brk_ovr (irq_brk_ovr)
);

// File: tb/tb_serial_rx_gated.sv
module tb_serial_rx_gated;

   localparam int BIT_CLK = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick16 = 1'b1;
   logic       rxd = 1'b1;
   logic       cfg_par_en = 1'b0;
   logic       cfg_par_odd = 1'b0;
   logic       cfg_two_stop = 1'b0;
   logic [4:0] cfg_trigger = 5'd4;
   logic       en_rx_irq = 1'b1;
   logic       en_err_irq = 1'b0;
   logic       clr_err = 1'b0;
   logic       clr_brk = 1'b0;
   logic       clr_ovr = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] rd_data;
   logic       rd_perr;
   logic       rd_ferr;
   logic [4:0] fifo_count;
   logic       flag_fill;
   logic       flag_err;
   logic       flag_brk;
   logic       flag_ovr;
   logic       irq_fill;
   logic       irq_rx_err;
   logic       irq_brk_ovr;

   serial_rx_gated dut (
      .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
      .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_two_stop(cfg_two_stop),
      .cfg_trigger(cfg_trigger), .en_rx_irq(en_rx_irq), .en_err_irq(en_err_irq),
      .clr_err(clr_err), .clr_brk(clr_brk), .clr_ovr(clr_ovr), .rd_en(rd_en),
      .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr), .fifo_count(fifo_count),
      .flag_fill(flag_fill), .flag_err(flag_err), .flag_brk(flag_brk), .flag_ovr(flag_ovr),
      .irq_fill(irq_fill), .irq_rx_err(irq_rx_err), .irq_brk_ovr(irq_brk_ovr)
   );

   always #10 clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit monitor_on = 0;
   bit finished = 0;

   logic [9:0] exp_q[$];
   bit m_err = 0;
   bit m_brk = 0;
   bit m_ovr = 0;

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic int eff_trig(input int raw);
      if (raw == 0) return 1;
      if (raw > 16) return 16;
      return raw;
   endfunction

   // per-clock comparison of the combinational results (R10, R11)
   always @(negedge clk) begin
      #2;
      if (monitor_on && !finished) begin
         automatic bit fill_e = (int'(fifo_count) >= eff_trig(int'(cfg_trigger)));
         automatic bit any_en = en_rx_irq | en_err_irq;
         chk("R10", "flag_fill", flag_fill, fill_e);
         chk("R11", "irq_fill", irq_fill, en_rx_irq & fill_e);
         chk("R11", "irq_rx_err", irq_rx_err, any_en & flag_err);
         chk("R11", "irq_brk_ovr", irq_brk_ovr, any_en & (flag_brk | flag_ovr));
      end
   end

   task automatic hold_bit(input bit b, input int clocks);
      rxd = b;
      repeat (clocks) @(negedge clk);
   endtask

   task automatic send_frame(input logic [7:0] d, input bit bad_par,
                             input bit stop1, input bit stop2, input int extra_low);
      automatic bit par = (^d) ^ cfg_par_odd ^ bad_par;
      automatic bit brk;
      automatic bit perr;
      automatic bit ferr;
      hold_bit(1'b0, BIT_CLK);
      for (int i = 0; i < 8; i++) hold_bit(d[i], BIT_CLK);
      if (cfg_par_en) hold_bit(par, BIT_CLK);
      hold_bit(stop1, BIT_CLK);
      if (cfg_two_stop) hold_bit(stop2, BIT_CLK);
      if (extra_low > 0) hold_bit(1'b0, extra_low);
      hold_bit(1'b1, 2 * BIT_CLK);
      brk  = (d == 8'h00) && (!cfg_par_en || !par) && !stop1;
      perr = cfg_par_en && bad_par;
      ferr = !stop1;
      if (brk) begin
         m_brk = 1;
         m_err = 1;
      end else begin
         if (perr || ferr) m_err = 1;
         if (exp_q.size() == 16) m_ovr = 1;
         else if (!m_brk && !m_ovr) exp_q.push_back({perr, ferr, d});
      end
   endtask

   task automatic compare_state(input string req);
      chk(req, "fifo_count", fifo_count, exp_q.size());
      chk(req, "flag_err", flag_err, m_err);
      chk(req, "flag_brk", flag_brk, m_brk);
      chk(req, "flag_ovr", flag_ovr, m_ovr);
   endtask

   task automatic pop_check(input string req);
      automatic logic [9:0] e = exp_q.pop_front();
      @(negedge clk);
      chk(req, "rd_data", rd_data, e[7:0]);
      chk(req, "rd_ferr", rd_ferr, e[8]);
      chk(req, "rd_perr", rd_perr, e[9]);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic pulse_clear(input int which);
      @(negedge clk);
      case (which)
         0: begin clr_err = 1'b1; m_err = 0; end
         1: begin clr_brk = 1'b1; m_brk = 0; end
         default: begin clr_ovr = 1'b1; m_ovr = 0; end
      endcase
      @(negedge clk);
      clr_err = 1'b0;
      clr_brk = 1'b0;
      clr_ovr = 1'b0;
   endtask

   task automatic summary();
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1 reset state
      chk("R1", "fifo_count", fifo_count, 0);
      chk("R1", "flags", {flag_fill, flag_err, flag_brk, flag_ovr}, 0);
      chk("R1", "irqs", {irq_fill, irq_rx_err, irq_brk_ovr}, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      monitor_on = 1;
      compare_state("R1");

      // R3 plain 8N1 data, LSB first
      send_frame(8'hA5, 0, 1, 1, 0);
      send_frame(8'h3C, 0, 1, 1, 0);
      send_frame(8'h01, 0, 1, 1, 0);
      compare_state("R3");
      repeat (3) pop_check("R3");

      // R3 parity even then odd
      cfg_par_en = 1'b1;
      send_frame(8'h7E, 0, 1, 1, 0);
      cfg_par_odd = 1'b1;
      send_frame(8'h81, 0, 1, 1, 0);
      compare_state("R3");
      repeat (2) pop_check("R3");

      // R5 parity error stored, reception continues
      send_frame(8'h55, 1, 1, 1, 0);
      send_frame(8'h66, 0, 1, 1, 0);
      compare_state("R5");
      repeat (2) pop_check("R5");
      pulse_clear(0);
      compare_state("R9");

      // R4 first stop bit low, second stop bit ignored
      cfg_par_en = 1'b0;
      cfg_par_odd = 1'b0;
      send_frame(8'h12, 0, 0, 1, 0);
      cfg_two_stop = 1'b1;
      send_frame(8'h34, 0, 1, 0, 0);
      compare_state("R4");
      repeat (2) pop_check("R4");
      pulse_clear(0);
      cfg_two_stop = 1'b0;

      // R2 short low pulse rejected
      hold_bit(1'b0, 4);
      hold_bit(1'b1, 4 * BIT_CLK);
      compare_state("R2");

      // R10 trigger level, zero acts as one
      cfg_trigger = 5'd3;
      send_frame(8'hC1, 0, 1, 1, 0);
      send_frame(8'hC2, 0, 1, 1, 0);
      chk("R10", "flag_fill below", flag_fill, 0);
      send_frame(8'hC3, 0, 1, 1, 0);
      chk("R10", "flag_fill at", flag_fill, 1);
      repeat (3) pop_check("R10");
      cfg_trigger = 5'd0;
      send_frame(8'h5A, 0, 1, 1, 0);
      chk("R10", "flag_fill trig0", flag_fill, 1);
      pop_check("R10");
      cfg_trigger = 5'd4;

      // R6 break with long low; shared enable for R11
      en_rx_irq = 1'b0;
      en_err_irq = 1'b1;
      send_frame(8'h00, 0, 0, 1, 3 * BIT_CLK);
      compare_state("R6");
      chk("R11", "irq_brk_ovr via err enable", irq_brk_ovr, 1);
      chk("R11", "irq_rx_err via err enable", irq_rx_err, 1);

      // R8 gated while break pending
      send_frame(8'h99, 0, 1, 1, 0);
      compare_state("R8");
      pulse_clear(1);
      pulse_clear(0);
      en_rx_irq = 1'b1;
      send_frame(8'h99, 0, 1, 1, 0);
      compare_state("R8");

      // R7 overrun
      for (int i = 0; i < 15; i++) send_frame(8'(8'h10 + i), 0, 1, 1, 0);
      compare_state("R10");
      send_frame(8'hF0, 0, 1, 1, 0);
      compare_state("R7");
      pop_check("R7");
      send_frame(8'h0F, 0, 1, 1, 0);
      compare_state("R8");
      pulse_clear(2);
      send_frame(8'hEE, 0, 1, 1, 0);
      compare_state("R7");
      while (exp_q.size() > 0) pop_check("R7");
      compare_state("R10");

      repeat (4) @(negedge clk);
      summary();
   end

endmodule